// File: doc/BRIEF.md
# VME Bus Ownership Requester

This block obtains VME bus ownership for a local bus master. The master raises a want-bus signal and holds off any bus cycle until the block returns a grant-bus acknowledge. While that request is open, the block drives one of four bus-request levels. It watches the daisy-chained grant-in line of that same level. When the grant arrives and the bus is no longer busy, the block takes bus-busy and acknowledges the master.

Grants on levels this board is not waiting on travel straight through to the grant-out line for the next board. A release-policy input sets when ownership is given up. In release-when-done mode, busy drops once the master withdraws want-bus. In release-on-request mode, the block parks on the bus after want-bus is withdrawn. It then gives the bus up only when another board raises a request line or the arbiter raises bus-clear. A new want-bus while parked is acknowledged without any arbitration.

The VME-side inputs are asynchronous to the block clock, so each passes through a two-flop synchroniser before the state machine uses it. All bus lines are shown active-high, which means "line asserted". The open-collector drivers and inversion sit outside this block.

Top module: `vmeReqTop`

## Requirements
- R1: After reset, the grant acknowledge, busy drive, all four request drives and all four grant-out lines are low.
- R2: When want-bus is high in the idle state, exactly one request line is driven from the next clock. The line is brOut bit n, where n is the 2-bit value of reqLevel (0 to 3), captured at that edge.
- R3: While requesting on level n, a grant seen on bgIn bit n with busyIn low makes the block assert grantBus and busyOut and drop its request line. This happens SYNC_STAGES+1 clocks after the inputs change.
- R4: While busyIn is high, a grant on the requesting level does not cause busyOut or grantBus to be asserted, and the request line stays driven.
- R5: A grant on any level other than the one being requested never causes grantBus or busyOut to rise.
- R6: A grant on bgIn bit i appears on bgOut bit i SYNC_STAGES clocks later, unless the block is requesting or owning on level i. In that case bgOut bit i stays low.
- R7: In release-when-done mode (relOnReq low), once want-bus is low and the minimum hold has elapsed, busyOut and grantBus fall at the next clock.
- R8: busyOut, once asserted, stays high for at least MIN_HOLD clocks, even if want-bus drops at once.
- R9: In release-on-request mode (relOnReq high), grantBus falls when want-bus is withdrawn, but busyOut stays high.
- R10: While parked, busyOut falls SYNC_STAGES+1 clocks after another request line or bus-clear goes high. Those inputs have no effect on busyOut while want-bus is high.
- R11: While parked, a new want-bus raises grantBus at the next clock, and no request line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wantBus | input | 1 | Local master wants the bus |
| grantBus | output | 1 | Bus granted to local master |
| relOnReq | input | 1 | 1: keep ownership until request/clear, 0: release when done |
| reqLevel | input | 2 | Request level to use (0..3) |
| brOut | output | 4 | Bus request drive, one bit per level |
| brIn | input | 4 | Observed bus request lines |
| bgIn | input | 4 | Daisy-chain grant in, one bit per level |
| bgOut | output | 4 | Daisy-chain grant out, one bit per level |
| busyOut | output | 1 | Bus-busy drive |
| busyIn | input | 1 | Observed bus-busy line |
| clrIn | input | 1 | Observed bus-clear line |

## Verification
The bench builds the block with SYNC_STAGES = 2 and MIN_HOLD = 3. With a hold that short, the case where want-bus is withdrawn right after the grant lands on the hold boundary within a few clocks. The bench sweeps every request level in both release modes. On even levels a foreign request line forces the release, and on odd levels bus-clear does. It also drives all sixteen grant-in patterns through the idle pass-through and checks the mixed patterns where only the requested level must be held back.

// File: rtl/vmeReqPkg.sv
package vmeReqPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_PARK = 2'd3
  } reqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lvlLoad;
    logic reqDrive;
    logic busyDrive;
    logic grantDrive;
    logic holdClr;
    logic blockPass;
  } ctlStrobes_t;

  // conditions from datapath to control
  typedef struct packed {
    logic bgMine;
    logic busyFree;
    logic otherReq;
    logic clrSeen;
    logic holdDone;
  } pathStatus_t;

endpackage

// File: rtl/vmeReqSync.sv
module vmeReqSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else if (s == 0) chain[s] <= dIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/vmeReqPath.sv
module vmeReqPath
  import vmeReqPkg::*;
#(
  parameter int LEVELS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [$clog2(LEVELS)-1:0] reqLevel,
  input  logic [LEVELS-1:0] brIn,
  input  logic [LEVELS-1:0] bgIn,
  input  logic              busyIn,
  input  logic              clrIn,
  output pathStatus_t       status,
  output logic [LEVELS-1:0] brOut,
  output logic [LEVELS-1:0] bgOut,
  output logic              busyOut,
  output logic              grantBus
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int SYNC_W = 2*LEVELS + 2;
  localparam int CNT_W  = $clog2(MIN_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_HOLD - 1);

  logic [SYNC_W-1:0] syncOut;
  logic [LEVELS-1:0] bgSync, brSync;
  logic              busySync, clrSync;
  logic [LVL_W-1:0]  lvlQ;
  logic [LEVELS-1:0] lvlMask;
  logic [CNT_W-1:0]  holdCnt;

  vmeReqSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) busSync_i (
    .clk (clk),
    .rstN(rstN),
    .dIn ({clrIn, busyIn, brIn, bgIn}),
    .dOut(syncOut)
  );

  assign {clrSync, busySync, brSync, bgSync} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlQ <= '0;
    else if (strobes.lvlLoad) lvlQ <= reqLevel;
  end

  generate
    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
      assign lvlMask[i] = (lvlQ == LVL_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (strobes.holdClr) holdCnt <= '0;
    else if (strobes.busyDrive && holdCnt != HOLD_LAST) holdCnt <= holdCnt + 1'b1;
  end

  assign brOut    = strobes.reqDrive ? lvlMask : '0;
  assign bgOut    = bgSync & ~(strobes.blockPass ? lvlMask : '0);
  assign busyOut  = strobes.busyDrive;
  assign grantBus = strobes.grantDrive;

  assign status.bgMine   = |(bgSync & lvlMask);
  assign status.busyFree = ~busySync;
  assign status.otherReq = |(brSync & ~brOut);
  assign status.clrSeen  = clrSync;
  assign status.holdDone = (holdCnt == HOLD_LAST);

  // independent run-length of busy for the hold check
  logic [CNT_W-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (!strobes.busyDrive) busyRun <= '0;
    else if (busyRun != CNT_W'(MIN_HOLD)) busyRun <= busyRun + 1'b1;
  end

  // R8
  busy_min_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> busyRun >= CNT_W'(MIN_HOLD));

  // R2
  br_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(brOut));

  // R6
  no_pass_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brOut & bgOut) == '0);
endmodule

// File: rtl/vmeReqCtrl.sv
module vmeReqCtrl
  import vmeReqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wantBus,
  input  logic        relOnReq,
  input  pathStatus_t status,
  output ctlStrobes_t strobes
);
  reqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (wantBus) stateNext = ST_REQ;
      ST_REQ:  if (status.bgMine && status.busyFree) stateNext = ST_OWN;
      ST_OWN:  if (!wantBus && status.holdDone)
                 stateNext = relOnReq ? ST_PARK : ST_IDLE;
      ST_PARK: begin
        if (wantBus) stateNext = ST_OWN;
        else if (!relOnReq || status.otherReq || status.clrSeen) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.lvlLoad    = (state == ST_IDLE);
    strobes.holdClr    = (state == ST_IDLE) || (state == ST_REQ);
    strobes.reqDrive   = (state == ST_REQ);
    strobes.blockPass  = (state == ST_REQ) || (state == ST_OWN);
    strobes.busyDrive  = (state == ST_OWN) || (state == ST_PARK);
    strobes.grantDrive = (state == ST_OWN);
  end

  // R4
  busy_take_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.busyDrive) |-> $past(status.busyFree));

  // R5
  grant_mine_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(strobes.grantDrive) && $past(strobes.reqDrive)) |-> $past(status.bgMine));
endmodule

// File: rtl/vmeReqTop.sv
module vmeReqTop
  import vmeReqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wantBus,
  output logic       grantBus,
  input  logic       relOnReq,
  input  logic [1:0] reqLevel,
  output logic [3:0] brOut,
  input  logic [3:0] brIn,
  input  logic [3:0] bgIn,
  output logic [3:0] bgOut,
  output logic       busyOut,
  input  logic       busyIn,
  input  logic       clrIn
);
  ctlStrobes_t strobes;
  pathStatus_t status;

  vmeReqCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wantBus (wantBus),
    .relOnReq(relOnReq),
    .status  (status),
    .strobes (strobes)
  );

  vmeReqPath #(.LEVELS(4), .SYNC_STAGES(SYNC_STAGES), .MIN_HOLD(MIN_HOLD)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqLevel(reqLevel),
    .brIn    (brIn),
    .bgIn    (bgIn),
    .busyIn  (busyIn),
    .clrIn   (clrIn),
    .status  (status),
    .brOut   (brOut),
    .bgOut   (bgOut),
    .busyOut (busyOut),
    .grantBus(grantBus)
  );

  // R11
  park_regrant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(grantBus) && $past(busyOut)) |-> brOut == 4'b0000);
endmodule

// File: tb/vmeReqTop_tb.sv
module vmeReqTop_tb_top;
  localparam int SYNC = 2;
  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wantBus = 1'b0, relOnReq = 1'b0, busyIn = 1'b0, clrIn = 1'b0;
  logic [1:0] reqLevel = 2'd0;
  logic [3:0] brIn = 4'h0, bgIn = 4'h0;
  logic       grantBus, busyOut;
  logic [3:0] brOut, bgOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vmeReqTop #(.SYNC_STAGES(SYNC), .MIN_HOLD(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .wantBus(wantBus), .grantBus(grantBus),
    .relOnReq(relOnReq), .reqLevel(reqLevel), .brOut(brOut), .brIn(brIn),
    .bgIn(bgIn), .bgOut(bgOut), .busyOut(busyOut), .busyIn(busyIn), .clrIn(clrIn)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 grant", {3'b0, grantBus}, 4'h0);
    check("R1 busy", {3'b0, busyOut}, 4'h0);
    check("R1 br", brOut, 4'h0);
    check("R1 bgOut", bgOut, 4'h0);

    // R6 idle pass-through, all patterns
    for (int p = 0; p < 16; p++) begin
      bgIn = 4'(p);
      tick(SYNC);
      check("R6 idle pass", bgOut, 4'(p));
    end
    bgIn = 4'h0;
    tick(SYNC + 1);

    for (int mode = 0; mode < 2; mode++) begin
      for (int lvl = 0; lvl < 4; lvl++) begin
        logic [3:0] mine;
        mine = 4'(1 << lvl);
        relOnReq = mode[0];
        reqLevel = 2'(lvl);
        wantBus  = 1'b1;
        tick(1);
        check("R2 request line", brOut, mine);
        check("R2 no grant yet", {3'b0, grantBus}, 4'h0);

        // R5 foreign grants only
        bgIn = 4'hF & ~mine;
        tick(SYNC + 2);
        check("R5 no grant", {3'b0, grantBus}, 4'h0);
        check("R5 no busy", {3'b0, busyOut}, 4'h0);
        check("R6 foreign passed", bgOut, 4'hF & ~mine);

        // R4 own grant but bus still busy
        bgIn = 4'hF;
        busyIn = 1'b1;
        tick(SYNC + 2);
        check("R4 held off", {2'b0, grantBus, busyOut}, 4'h0);
        check("R4 request kept", brOut, mine);
        check("R6 own blocked", bgOut, 4'hF & ~mine);

        // R3 bus frees
        busyIn = 1'b0;
        tick(SYNC);
        check("R3 not before sync", {3'b0, grantBus}, 4'h0);
        tick(1);
        check("R3 grant+busy", {2'b0, grantBus, busyOut}, 4'h3);
        check("R3 request dropped", brOut, 4'h0);

        // R8 immediate withdraw
        bgIn = 4'h0;
        wantBus = 1'b0;
        tick(1);
        check("R8 busy held", {3'b0, busyOut}, 4'h1);
        tick(HOLD - 2);
        check("R8 busy held to limit", {3'b0, busyOut}, 4'h1);
        tick(1);
        if (mode == 0) begin
          check("R7 release when done", {2'b0, grantBus, busyOut}, 4'h0);
        end else begin
          check("R9 parked", {2'b0, grantBus, busyOut}, 4'h1);
          // R11 regrant while parked
          wantBus = 1'b1;
          if (lvl % 2 == 0) brIn = 4'(1 << ((lvl + 1) % 4));
          else clrIn = 1'b1;
          tick(1);
          check("R11 regrant", {2'b0, grantBus, busyOut}, 4'h3);
          check("R11 no request", brOut, 4'h0);
          tick(SYNC + 1);
          check("R10 ignored while wanted", {2'b0, grantBus, busyOut}, 4'h3);
          wantBus = 1'b0;
          tick(1);
          check("R9 parked again", {2'b0, grantBus, busyOut}, 4'h1);
          tick(1);
          check("R10 released", {3'b0, busyOut}, 4'h0);
          brIn = 4'h0;
          clrIn = 1'b0;
        end
        tick(SYNC + 2);
      end
    end

    // R10 delay from a fresh request line while parked
    relOnReq = 1'b1;
    reqLevel = 2'd2;
    wantBus = 1'b1;
    bgIn = 4'h4;
    tick(SYNC + 2);
    check("R3 grant lvl2", {2'b0, grantBus, busyOut}, 4'h3);
    bgIn = 4'h0;
    wantBus = 1'b0;
    tick(HOLD + 1);
    check("R9 parked lvl2", {2'b0, grantBus, busyOut}, 4'h1);
    brIn = 4'h1;
    tick(SYNC);
    check("R10 still parked", {3'b0, busyOut}, 4'h1);
    tick(1);
    check("R10 release delay", {3'b0, busyOut}, 4'h0);
    brIn = 4'h0;
    tick(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule